// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block is a watchdog timer that runs from a slow low-frequency timebase and is reached through a small 16-bit register port. Software configures a timeout, starts the timer and must then keep it alive. A free-running prescaler divides the slow clock into half-second ticks, and a down-counter counts those ticks. The only way to reload the counter is a two-word unlock: 0x5555 written to the service register, followed directly by 0xAAAA. If the counter runs out, the block requests either an internal chip reset or an external active-low reset, as the control register selects. Once the watchdog has been started, it cannot be stopped.

Software can also request either reset directly. The software request must be written twice within a short window before it takes effect. A reset-cause register keeps a flag that tells a timeout reset apart from other resets. This flag is cleared only by power-on reset, so it survives the chip reset that the watchdog itself causes.

There is also a one-shot power-down counter that starts at every reset. When it expires, it pulses an active-low interrupt line for one cycle, unless software has switched it off first. An optional pause bit, which can be written only once, freezes counting while a low-power input is high.

Top module: `svc_watchdog`

## Requirements
- R1: After power-on reset the registers read as follows:
  - control (address 0x0) reads 0x0030
  - service (0x2) reads 0x0000
  - reset cause (0x4) reads 0x0000
  - misc (0x8) reads 0x0001

  At the same time `intRstReq` is 0, `extRstN` is 1 and `pdIntN` is 1.
- R2: The timeout value N sits in control bits 15:8, and control bit 2 is the run bit.
  - While bit 2 is 0, the block never expires.
  - A control write that sets bit 2 loads the counter with N. The resulting reset is visible (N+1)*TICK_DIV+1 cycles after that write's clock edge.
- R3: A reload happens only when a service write of 0xAAAA is the very next register write after a service write of 0x5555. Any other write in between, to any register, cancels the pending first word.
- R4: Once control bit 2 is 1, it reads back as 1, and writing 0 to it does not stop the timer.
- R5: Control bit 0 (pause in low power) is taken only from the first control write after reset. While it is 1 and `lowPower` is high, the prescaler and the counter hold their values.
- R6: Writing 0 to control bit 4 is a software reset request.
  - The request takes effect only if a second such write arrives within SRS_WINDOW cycles of the first.
  - Two such writes SRS_WINDOW+1 or more cycles apart have no effect.
  - Once asserted, `intRstReq` stays high until `sysRstN` or `porN` is applied.
- R7: Control bit 5 is an active-low external reset request. While it holds 0, `extRstN` is low.
- R8: Control bit 3 chooses the expiry action.
  - When it is 0, expiry asserts `intRstReq`.
  - When it is 1, expiry pulls only `extRstN` low and `intRstReq` stays 0.
- R9: Bit 1 of the reset-cause register is handled as follows:
  - It is set when a timeout raises `intRstReq`.
  - It is cleared when a software request raises `intRstReq`.
  - It keeps its value through `sysRstN` and is cleared only by `porN`.
- R10: The power-down counter starts at every reset. It drives `pdIntN` low for exactly one cycle after the PD_CYCLES-th clock edge following reset release. Writing a 0 to misc bit 0 before then cancels the pulse, and bit 0 then reads 0.
- R11: Rewriting the timeout field while the timer runs does not reload the counter. The new value is used from the next service reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow timebase clock; also clocks the register port |
| porN | input | 1 | Power-on reset, active low; clears everything |
| sysRstN | input | 1 | Chip reset, active low; clears everything except the reset-cause flag |
| regWrite | input | 1 | Register write strobe for this cycle |
| regAddr | input | 4 | Register byte address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| lowPower | input | 1 | Low-power indication that pauses counting when enabled |
| intRstReq | output | 1 | Internal chip reset request, active high, held |
| extRstN | output | 1 | External reset output, active low |
| pdIntN | output | 1 | Power-down counter interrupt, active-low one-cycle pulse |

## Verification
The expiry path is checked against several patterns:
- A plain start with no service sets the baseline expiry cycle.
- A correct unlock pair moves the expiry to count from the 0xAAAA edge.
- Broken pairs, with a wrong service word or an unrelated register write between the two keys, must leave the original expiry cycle unchanged. This separates a true sequence check from a checker that only looks for the second key.

A timeout rewrite followed by a service pair shows whether the new field is taken at the rewrite or at the reload. A paused start shows that the low-power bit freezes the prescaler as well as the counter. Software requests written two and three cycles apart confirm that the window is enforced.

// File: rtl/svcwd_pkg.sv
package svcwd_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int TO_W   = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_MISC = 4'h8;

  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

  // Strobes from control to datapath for a single cycle
  typedef struct packed {
    logic            start;    // run bit set for the first time
    logic            reload;   // valid unlock pair completed
    logic [TO_W-1:0] loadVal;  // value to load on start or reload
  } strobe_t;

  // Settings held in control, used by datapath
  typedef struct packed {
    logic enabled;
    logic lpPause;
    logic pdEn;
  } cfg_t;

endpackage

// File: rtl/svcwd_ctrl.sv
module svcwd_ctrl
  import svcwd_pkg::*;
#(
  parameter int SRS_WINDOW = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              expirePulse,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic              intRstReq,
  output logic              extRstN
);

  localparam int WIN_W = $clog2(SRS_WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(SRS_WINDOW);

  logic [TO_W-1:0]  timeoutVal;
  logic             toSel;
  logic             enBit;
  logic             lpBit;
  logic             lpLocked;
  logic             extAssert;
  logic             pdEn;
  logic             armed;
  logic [WIN_W-1:0] srsCnt;
  logic             intReq;
  logic             extTimedOut;
  logic             causeTimeout;
  logic [2:0]       unusedWdata;

  logic wrCtrl, wrSvc, wrMisc, srsWrite, srsFire;

  assign wrCtrl   = regWrite && (regAddr == ADDR_CTRL);
  assign wrSvc    = regWrite && (regAddr == ADDR_SVC);
  assign wrMisc   = regWrite && (regAddr == ADDR_MISC);
  assign srsWrite = wrCtrl && !regWdata[4];
  assign srsFire  = srsWrite && (srsCnt != '0);

  assign unusedWdata = {regWdata[7:6], regWdata[1]};

  always_comb begin
    stb.start   = wrCtrl && regWdata[2] && !enBit;
    stb.reload  = wrSvc && (regWdata == KEY_SECOND) && armed;
    stb.loadVal = stb.start ? regWdata[15:8] : timeoutVal;
  end

  always_comb begin
    cfg.enabled = enBit;
    cfg.lpPause = lpBit;
    cfg.pdEn    = pdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutVal  <= '0;
      toSel       <= 1'b0;
      enBit       <= 1'b0;
      lpBit       <= 1'b0;
      lpLocked    <= 1'b0;
      extAssert   <= 1'b0;
      pdEn        <= 1'b1;
      armed       <= 1'b0;
      srsCnt      <= '0;
      intReq      <= 1'b0;
      extTimedOut <= 1'b0;
    end else begin
      if (wrCtrl) begin
        timeoutVal <= regWdata[15:8];
        toSel      <= regWdata[3];
        extAssert  <= !regWdata[5];
        if (regWdata[2]) enBit <= 1'b1;
        if (!lpLocked) begin
          lpBit    <= regWdata[0];
          lpLocked <= 1'b1;
        end
      end
      if (regWrite) armed <= wrSvc && (regWdata == KEY_FIRST);
      if (srsWrite && (srsCnt == '0)) srsCnt <= WIN_LOAD;
      else if (srsCnt != '0)          srsCnt <= srsCnt - WIN_W'(1);
      if (wrMisc && !regWdata[0]) pdEn <= 1'b0;
      if (srsFire || (expirePulse && !toSel)) intReq <= 1'b1;
      if (expirePulse && toSel) extTimedOut <= 1'b1;
    end
  end

  // Cause flag lives in the power-on domain only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      causeTimeout <= 1'b0;
    end else if (!intReq) begin
      if (expirePulse && !toSel) causeTimeout <= 1'b1;
      else if (srsFire)          causeTimeout <= 1'b0;
    end
  end

  assign intRstReq = intReq;
  assign extRstN   = !(extAssert || extTimedOut);

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {timeoutVal, 2'b00, !extAssert, 1'b1, toSel, enBit, 1'b0, lpBit};
      ADDR_STAT: regRdata = {14'd0, causeTimeout, 1'b0};
      ADDR_MISC: regRdata = {15'd0, pdEn};
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/svcwd_datapath.sv
module svcwd_datapath
  import svcwd_pkg::*;
#(
  parameter int TICK_DIV  = 16384,
  parameter int PD_CYCLES = 524288
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lowPower,
  input  cfg_t    cfg,
  input  strobe_t stb,
  output logic    expirePulse,
  output logic    pdIntN
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PD_W  = (PD_CYCLES > 1) ? $clog2(PD_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [PD_W-1:0]  PD_LAST  = PD_W'(PD_CYCLES - 1);

  logic [PRE_W-1:0] pre;
  logic [TO_W-1:0]  cnt;
  logic             fired;
  logic             pdRun;
  logic             pdPulse;
  logic [PD_W-1:0]  pdCnt;

  logic paused, running, tick, loadNow;

  assign paused  = lowPower && cfg.lpPause;
  assign running = cfg.enabled && !fired && !paused;
  assign tick    = running && (pre == PRE_LAST);
  assign loadNow = stb.start || stb.reload;

  // Half-second prescaler and timeout down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre         <= '0;
      cnt         <= '0;
      fired       <= 1'b0;
      expirePulse <= 1'b0;
    end else begin
      expirePulse <= 1'b0;
      if (loadNow && !fired) begin
        cnt <= stb.loadVal;
        pre <= '0;
      end else if (running) begin
        if (tick) begin
          pre <= '0;
          if (cnt == '0) begin
            fired       <= 1'b1;
            expirePulse <= 1'b1;
          end else begin
            cnt <= cnt - TO_W'(1);
          end
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end
  end

  // One-shot power-down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdRun   <= 1'b1;
      pdCnt   <= '0;
      pdPulse <= 1'b0;
    end else begin
      pdPulse <= 1'b0;
      if (pdRun) begin
        if (!cfg.pdEn) begin
          pdRun <= 1'b0;
        end else if (pdCnt == PD_LAST) begin
          pdPulse <= 1'b1;
          pdRun   <= 1'b0;
        end else begin
          pdCnt <= pdCnt + PD_W'(1);
        end
      end
    end
  end

  assign pdIntN = !pdPulse;

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svcwd_pkg::*;
#(
  parameter int TICK_DIV   = 16384,
  parameter int PD_CYCLES  = 524288,
  parameter int SRS_WINDOW = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              lowPower,
  output logic              intRstReq,
  output logic              extRstN,
  output logic              pdIntN
);

  logic    rstN;
  cfg_t    cfg;
  strobe_t stb;
  logic    expirePulse;

  assign rstN = porN && sysRstN;

  svcwd_ctrl #(.SRS_WINDOW(SRS_WINDOW)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .expirePulse(expirePulse), .cfg(cfg), .stb(stb),
    .intRstReq(intRstReq), .extRstN(extRstN)
  );

  svcwd_datapath #(.TICK_DIV(TICK_DIV), .PD_CYCLES(PD_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .lowPower(lowPower),
    .cfg(cfg), .stb(stb), .expirePulse(expirePulse), .pdIntN(pdIntN)
  );

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk
  import svcwd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWdata,
  input logic              intRstReq,
  input logic              extRstN,
  input logic              pdIntN,
  input cfg_t              cfg,
  input strobe_t           stb,
  input logic              expirePulse
);

  logic lastKey1;
  logic seenCtrlWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastKey1   <= 1'b0;
      seenCtrlWr <= 1'b0;
    end else if (regWrite) begin
      lastKey1 <= (regAddr == ADDR_SVC) && (regWdata == KEY_FIRST);
      if (regAddr == ADDR_CTRL) seenCtrlWr <= 1'b1;
    end
  end

  p_expire_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> cfg.enabled);

  p_reload_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |-> (lastKey1 && regWrite && regAddr == ADDR_SVC && regWdata == KEY_SECOND));

  p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfg.enabled |=> cfg.enabled);

  p_pause_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seenCtrlWr && regWrite && regAddr == ADDR_CTRL) |=> $stable(cfg.lpPause));

  p_int_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    intRstReq |=> intRstReq);

  p_ext_request_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_CTRL && !regWdata[5]) |=> !extRstN);

  p_pd_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pdIntN |=> pdIntN);

endmodule

bind svc_watchdog svc_watchdog_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
  .intRstReq(intRstReq), .extRstN(extRstN), .pdIntN(pdIntN),
  .cfg(cfg), .stb(stb), .expirePulse(expirePulse)
);

// File: tb/svc_watchdog_test.sv
`timescale 1ns/1ps
module svc_watchdog_test;

  localparam int TD  = 4;
  localparam int PDC = 40;
  localparam int WIN = 2;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        regWrite = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic        lowPower = 1'b0;
  logic        intRstReq, extRstN, pdIntN;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int pdLow   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!pdIntN) pdLow <= pdLow + 1;

  svc_watchdog #(.TICK_DIV(TD), .PD_CYCLES(PDC), .SRS_WINDOW(WIN)) uut (
    .clk(clk), .porN(porN), .sysRstN(sysRstN),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .lowPower(lowPower), .intRstReq(intRstReq), .extRstN(extRstN), .pdIntN(pdIntN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input int n, input bit en, input bit sel = 1'b0,
                                     input bit lp = 1'b0, input bit extN = 1'b1,
                                     input bit srsN = 1'b1);
    logic [7:0] nv;
    nv = n[7:0];
    return {nv, 2'b00, extN, srsN, sel, en, 1'b0, lp};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d, output int at);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
    at = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdata;
  endtask

  task automatic porReset(output int rel);
    @(negedge clk);
    porN = 1'b0; sysRstN = 1'b1; regWrite = 1'b0; lowPower = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    rel = cyc;
  endtask

  task automatic sysReset();
    @(negedge clk);
    sysRstN = 1'b0; regWrite = 1'b0; lowPower = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
  endtask

  task automatic waitInt(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (intRstReq) begin at = cyc; break; end
    end
  endtask

  task automatic waitExtLow(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!extRstN) begin at = cyc; break; end
    end
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // R1, R10: reset values and power-down pulse timing
  task automatic t_reset_pd();
    int rel; logic [15:0] d;
    porReset(rel);
    rd(4'h0, d); chk("R1 ctrl reset", d, 16'h0030);
    rd(4'h2, d); chk("R1 svc reset", d, 16'h0000);
    rd(4'h4, d); chk("R1 cause reset", d, 16'h0000);
    rd(4'h8, d); chk("R1 misc reset", d, 16'h0001);
    chk("R1 outputs idle", {intRstReq, extRstN, pdIntN}, 3'b011);
    waitUntil(rel + PDC - 1);
    chk("R10 pd high before", pdIntN, 1'b1);
    waitUntil(rel + PDC);
    chk("R10 pd low", pdIntN, 1'b0);
    waitUntil(rel + PDC + 1);
    chk("R10 pd one cycle", pdIntN, 1'b1);
  endtask

  // R10: disable before expiry
  task automatic t_pd_off();
    int rel, w; logic [15:0] d;
    porReset(rel);
    wr(4'h8, 16'h0000, w);
    pdLow = 0;
    waitUntil(rel + PDC + 10);
    chk("R10 pd disabled no pulse", pdLow, 0);
    rd(4'h8, d); chk("R10 misc reads 0", d, 16'h0000);
  endtask

  // R2: no expiry while run bit is clear
  task automatic t_disabled();
    int w;
    sysReset();
    wr(4'h0, cw(0, 1'b0), w);
    repeat (60) @(negedge clk);
    chk("R2 disabled no reset", intRstReq, 1'b0);
  endtask

  // R2, R9: plain expiry timing, cause flag survives chip reset
  task automatic t_basic();
    int w, at; logic [15:0] d;
    sysReset();
    wr(4'h0, cw(2, 1'b1), w);
    waitInt(at);
    chk("R2 expiry cycle", at, w + 3 * TD + 1);
    repeat (3) @(negedge clk);
    chk("R6 int reset held", intRstReq, 1'b1);
    sysReset();
    rd(4'h4, d); chk("R9 cause after timeout", d, 16'h0002);
    rd(4'h0, d); chk("R2 ctrl cleared by chip reset", d, 16'h0030);
  endtask

  // R3: valid unlock pair reloads
  task automatic t_service();
    int w, w2, at;
    sysReset();
    wr(4'h0, cw(7, 1'b1), w);
    repeat (10) @(negedge clk);
    wr(4'h2, 16'h5555, w2);
    wr(4'h2, 16'hAAAA, w2);
    waitInt(at);
    chk("R3 reload moves expiry", at, w2 + 8 * TD + 1);
  endtask

  // R3: broken pairs do not reload
  task automatic t_badseq();
    int w, x, at;
    sysReset();
    wr(4'h0, cw(7, 1'b1), w);
    wr(4'h2, 16'h5555, x);
    wr(4'h2, 16'h1234, x);
    wr(4'h2, 16'hAAAA, x);
    wr(4'h2, 16'h5555, x);
    wr(4'h0, cw(7, 1'b1), x);
    wr(4'h2, 16'hAAAA, x);
    wr(4'h2, 16'hAAAA, x);
    waitInt(at);
    chk("R3 broken pairs ignored", at, w + 8 * TD + 1);
  endtask

  // R4: run bit cannot be cleared
  task automatic t_sticky();
    int w, x, at; logic [15:0] d;
    sysReset();
    wr(4'h0, cw(5, 1'b1), w);
    wr(4'h0, cw(5, 1'b0), x);
    rd(4'h0, d); chk("R4 run bit reads 1", d[2], 1'b1);
    waitInt(at);
    chk("R4 still expires", at, w + 6 * TD + 1);
  endtask

  // R11: new timeout applies at the next reload only
  task automatic t_rewrite();
    int w, w2, at;
    sysReset();
    wr(4'h0, cw(7, 1'b1), w);
    wr(4'h0, cw(1, 1'b1), w2);
    wr(4'h2, 16'h5555, w2);
    wr(4'h2, 16'hAAAA, w2);
    waitInt(at);
    chk("R11 new timeout at reload", at, w2 + 2 * TD + 1);
  endtask

  // R5: pause bit freezes counting and is write-once
  task automatic t_lp();
    int w, x, rel, at; logic [15:0] d;
    sysReset();
    @(negedge clk); lowPower = 1'b1;
    wr(4'h0, cw(1, 1'b1, 1'b0, 1'b1), w);
    repeat (30) @(negedge clk);
    chk("R5 paused no expiry", intRstReq, 1'b0);
    wr(4'h0, cw(1, 1'b1, 1'b0, 1'b0), x);
    rd(4'h0, d); chk("R5 pause bit write-once", d[0], 1'b1);
    @(negedge clk); lowPower = 1'b0; rel = cyc;
    waitInt(at);
    chk("R5 resumes after low power", at, rel + 2 * TD + 1);
  endtask

  // R6, R9: software reset needs two writes inside the window
  task automatic t_srs();
    int w, at; logic [15:0] d;
    sysReset();
    rd(4'h4, d); chk("R9 cause kept through chip reset", d, 16'h0002);
    wr(4'h0, cw(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), w);
    chk("R6 single request no reset", intRstReq, 1'b0);
    wr(4'h0, cw(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), w);
    chk("R6 double request resets", intRstReq, 1'b1);
    sysReset();
    rd(4'h4, d); chk("R9 cause after software reset", d, 16'h0000);
    wr(4'h0, cw(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), w);
    @(negedge clk);
    wr(4'h0, cw(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), w);
    chk("R6 spaced requests ignored", intRstReq, 1'b0);
    at = 0;
  endtask

  // R8: external-only expiry
  task automatic t_sel_ext();
    int w, at; logic [15:0] d;
    sysReset();
    wr(4'h0, cw(1, 1'b1, 1'b1), w);
    waitExtLow(at);
    chk("R8 external expiry cycle", at, w + 2 * TD + 1);
    chk("R8 no internal reset", intRstReq, 1'b0);
    rd(4'h4, d); chk("R8 cause untouched", d, 16'h0000);
  endtask

  // R7: external reset request bit
  task automatic t_ext_bit();
    int w;
    sysReset();
    wr(4'h0, cw(0, 1'b0, 1'b0, 1'b0, 1'b0), w);
    chk("R7 ext asserted", extRstN, 1'b0);
    wr(4'h0, cw(0, 1'b0), w);
    chk("R7 ext released", extRstN, 1'b1);
    chk("R7 no internal reset", intRstReq, 1'b0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    t_reset_pd();
    t_pd_off();
    t_disabled();
    t_basic();
    t_service();
    t_badseq();
    t_sticky();
    t_rewrite();
    t_lp();
    t_srs();
    t_sel_ext();
    t_ext_bit();
    finishRun();
  end

endmodule